// File: doc/BRIEF.md
# Write Byte-Enable and Lane Steering Unit

This unit sits on the write-data path of a wide memory-mapped bus master. A requester gives it a byte address, a size code and a write value whose least significant byte holds the first byte to store. The unit returns a per-byte enable mask and a full-width data word. The value is moved into the byte lanes chosen by the address, and the mask marks exactly those lanes. A slave that honours the mask then updates only the intended bytes.

Each transfer is a single beat of 1, 2, 4, 8 or 16 bytes. Aligned transfers fill a naturally aligned group of lanes. An unaligned transfer starts at the addressed lane and stops at the end of the size-aligned container that holds that lane. Value bytes that would fall past that boundary are discarded. Lanes that are not enabled carry zeros.

The result is held in one register stage behind a valid/ready handshake. The unit accepts a new request in the same cycle that the previous result is consumed, so it can take one transfer per clock.

Top module: `wr_lane_steer`

## Requirements
- R1: The enable mask has one bit per byte lane (16 bits for a 128-bit word), and mask bit n qualifies data bits 8n+7 down to 8n.
- R2: Size codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bytes. At an address aligned to the size, exactly that many adjacent mask bits are set, starting at the lane given by the low four address bits.
- R3: A one-byte transfer (size code 0) sets exactly one mask bit, the bit whose index equals address bits 3:0.
- R4: Byte k of the write value appears on lane (start lane + k). For example, a byte 0x02 at address 1 is driven on bits 15:8 with mask 0x0002.
- R5: For an unaligned start, the mask covers the lanes from the start lane up to the last lane of the size-aligned container, and no further. Value bytes beyond that lane are dropped.
- R6: Every lane whose mask bit is clear carries 0x00.
- R7: Size codes 5, 6 and 7 behave as code 4 (the full 16 bytes).
- R8: Address bits above bit 3 have no effect on the mask or on the data.
- R9: A request is taken on a clock edge where the input valid and the input ready are both high. Its result shows at the outputs after that edge, with the output valid set.
- R10: While the output valid is high and the output ready is low, the input ready is low and the output mask and data stay unchanged.
- R11: After reset, and whenever no result is pending, the output valid, the mask and the data are all zero.
- R12: While the output ready is high, the input ready is high, so back-to-back requests are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Unit can take a request |
| inAddr | input | ADDR_W (32) | Byte address of the first byte |
| inSize | input | SIZE_W (3) | Size code, bytes = 2^code, capped at full width |
| inData | input | 8*DATA_BYTES (128) | Write value, first byte in bits 7:0 |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Downstream takes the result |
| outStrb | output | DATA_BYTES (16) | Per-lane byte enable |
| outData | output | 8*DATA_BYTES (128) | Lane-steered write data |

## Verification
The bench builds the unit with its defaults: 16 lanes, a 32-bit address and a 3-bit size code. With these values every start lane from 0 to 15 can be combined with every size code, including the three oversize codes. This makes a complete sweep of lane against size possible, so the single-lane, aligned and boundary-trimmed cases are all covered in one pass. The wide address lets the bench set high address bits and show that they have no effect. Directed scenarios cover handshake stalls and back-to-back streaming.

// File: rtl/wr_lane_pkg.sv
package wr_lane_pkg;

  // Handshake control to datapath register strobes
  typedef struct packed {
    logic load;   // capture the freshly steered word
    logic clear;  // return the output registers to zero
  } laneCtrl_t;

  // Transfer size codes (bytes = 2**code)
  typedef enum logic [2:0] {
    SZ_1B  = 3'd0,
    SZ_2B  = 3'd1,
    SZ_4B  = 3'd2,
    SZ_8B  = 3'd3,
    SZ_16B = 3'd4
  } sizeCode_e;

endpackage

// File: rtl/wr_lane_ctrl.sv
module wr_lane_ctrl
  import wr_lane_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  output laneCtrl_t ctrl
);

  logic validQ;
  logic validD;

  // The single slot is free when it is empty or is being drained this cycle
  always_comb begin
    inReady    = !validQ || outReady;
    ctrl.load  = inValid && inReady;
    ctrl.clear = validQ && outReady && !inValid;
  end

  always_comb begin
    validD = validQ;
    if (ctrl.load) begin
      validD = 1'b1;
    end else if (outReady) begin
      validD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else begin
      validQ <= validD;
    end
  end

  assign outValid = validQ;

endmodule

// File: rtl/wr_lane_dpath.sv
module wr_lane_dpath
  import wr_lane_pkg::*;
#(
  parameter int DATA_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneCtrl_t               ctrl,
  input  logic [ADDR_W-1:0]       inAddr,
  input  logic [SIZE_W-1:0]       inSize,
  input  logic [8*DATA_BYTES-1:0] inData,
  output logic [DATA_BYTES-1:0]   outStrb,
  output logic [8*DATA_BYTES-1:0] outData
);

  localparam int DATA_W   = 8 * DATA_BYTES;
  localparam int LANE_W   = $clog2(DATA_BYTES);
  localparam int SIZE_MAX = LANE_W;

  logic [LANE_W-1:0] startLane;
  logic [LANE_W-1:0] sizeMask;
  logic [LANE_W-1:0] lastLane;
  logic [SIZE_W-1:0] effSize;
  logic [DATA_BYTES-1:0] nextStrb;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] nextData;

  // Oversize codes collapse onto the full-width transfer
  always_comb begin
    if (inSize > SIZE_W'(SIZE_MAX)) begin
      effSize = SIZE_W'(SIZE_MAX);
    end else begin
      effSize = inSize;
    end
  end

  // Container end: start lane with the size's low bits forced high
  always_comb begin
    startLane = inAddr[LANE_W-1:0];
    for (int j = 0; j < LANE_W; j++) begin
      sizeMask[j] = (j < int'(effSize));
    end
    lastLane = startLane | sizeMask;
  end

  always_comb begin
    for (int i = 0; i < DATA_BYTES; i++) begin
      nextStrb[i] = (i >= int'(startLane)) && (i <= int'(lastLane));
    end
  end

  // Move the right-justified value up to the start lane
  assign shifted = inData << {startLane, 3'b000};

  generate
    for (genvar g = 0; g < DATA_BYTES; g++) begin : gLane
      assign nextData[8*g +: 8] = shifted[8*g +: 8] & {8{nextStrb[g]}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outStrb <= '0;
      outData <= '0;
    end else if (ctrl.load) begin
      outStrb <= nextStrb;
      outData <= nextData;
    end else if (ctrl.clear) begin
      outStrb <= '0;
      outData <= '0;
    end
  end

endmodule

// File: rtl/wr_lane_steer.sv
module wr_lane_steer
  import wr_lane_pkg::*;
#(
  parameter int DATA_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [ADDR_W-1:0]       inAddr,
  input  logic [SIZE_W-1:0]       inSize,
  input  logic [8*DATA_BYTES-1:0] inData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [DATA_BYTES-1:0]   outStrb,
  output logic [8*DATA_BYTES-1:0] outData
);

  laneCtrl_t ctrl;

  wr_lane_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .ctrl     (ctrl)
  );

  wr_lane_dpath #(
    .DATA_BYTES (DATA_BYTES),
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inAddr  (inAddr),
    .inSize  (inSize),
    .inData  (inData),
    .outStrb (outStrb),
    .outData (outData)
  );

endmodule

// File: rtl/wr_lane_steer_chk.sv
module wr_lane_steer_chk #(
  parameter int DATA_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic [ADDR_W-1:0]       inAddr,
  input logic [SIZE_W-1:0]       inSize,
  input logic [8*DATA_BYTES-1:0] inData,
  input logic                    outValid,
  input logic                    outReady,
  input logic [DATA_BYTES-1:0]   outStrb,
  input logic [8*DATA_BYTES-1:0] outData
);

  logic [8*DATA_BYTES-1:0] laneMask;

  always_comb begin
    for (int i = 0; i < DATA_BYTES; i++) begin
      laneMask[8*i +: 8] = {8{outStrb[i]}};
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outStrb) && $stable(outData)); // R10

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid); // R9

  AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inSize == '0) |=> $countones(outStrb) == 1); // R3

  AST_VALID_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outStrb != '0); // R2

  AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outData & ~laneMask) == '0); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outStrb == '0) && (outData == '0)); // R11

  AST_DRAIN_READY: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady); // R12

endmodule

bind wr_lane_steer wr_lane_steer_chk #(
  .DATA_BYTES (DATA_BYTES),
  .ADDR_W     (ADDR_W),
  .SIZE_W     (SIZE_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inAddr   (inAddr),
  .inSize   (inSize),
  .inData   (inData),
  .outValid (outValid),
  .outReady (outReady),
  .outStrb  (outStrb),
  .outData  (outData)
);

// File: tb/wr_lane_steer_test.sv
module wr_lane_steer_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [31:0]  inAddr = '0;
  logic [2:0]   inSize = '0;
  logic [127:0] inData = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [15:0]  outStrb;
  logic [127:0] outData;

  int testsRun = 0;
  int testsFailed = 0;

  localparam logic [127:0] PATTERN = 128'h8F8E8D8C8B8A89888786858483828180;

  always #2 clk = ~clk;

  wr_lane_steer uut (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inReady (inReady),
    .inAddr (inAddr), .inSize (inSize), .inData (inData),
    .outValid (outValid), .outReady (outReady),
    .outStrb (outStrb), .outData (outData)
  );

  // Independent model: container base by division, lanes compared in range
  function automatic logic [15:0] modelStrb(logic [31:0] a, logic [2:0] s);
    int eff   = (s > 3'd4) ? 4 : int'(s);
    int bytes = 1 << eff;
    int lane  = int'(a % 16);
    int base  = (lane / bytes) * bytes;
    logic [15:0] m = '0;
    for (int b = 0; b < 16; b++) m[b] = (b >= lane) && (b < base + bytes);
    return m;
  endfunction

  function automatic logic [127:0] modelData(logic [31:0] a, logic [2:0] s, logic [127:0] v);
    logic [15:0] m = modelStrb(a, s);
    int lane = int'(a % 16);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++) if (m[b]) r[8*b +: 8] = v[8*(b-lane) +: 8];
    return r;
  endfunction

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge take it, sample at the next falling edge
  task automatic send(input logic [31:0] a, input logic [2:0] s, input logic [127:0] v, input string tag);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inSize = s; inData = v; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({127'd0, outValid}, 128'd1, {tag, " valid"});
    check({112'd0, outStrb}, {112'd0, modelStrb(a, s)}, {tag, " strb"});
    check(outData, modelData(a, s, v), {tag, " data"});
  endtask

  task automatic tReset();
    check({127'd0, outValid}, 128'd0, "R11 reset valid");
    check({112'd0, outStrb}, 128'd0, "R11 reset strb");
    check(outData, 128'd0, "R11 reset data");
    check({127'd0, inReady}, 128'd1, "R12 ready after reset");
  endtask

  task automatic tExamples();
    send(32'd1, 3'd0, 128'h02, "R4 byte at addr1");
    check(outData, 128'h0200, "R4 lane 15:8 holds 0x02");
    check({112'd0, outStrb}, 128'h0002, "R3 strobe 0x0002");
    send(32'd0, 3'd1, 128'h0202, "R2 halfword aligned");
    check({112'd0, outStrb}, 128'h0003, "R2 two adjacent lanes");
    send(32'd0, 3'd0, 128'h02, "R1 lane zero");
    check(outData, 128'h02, "R1 bits 7:0");
  endtask

  task automatic tUnaligned();
    send(32'd3, 3'd2, PATTERN, "R5 word at 3");
    check({112'd0, outStrb}, 128'h0008, "R5 trimmed to lane 3");
    check(outData, 128'h80000000, "R5 first byte only");
    send(32'd5, 3'd3, PATTERN, "R5 dword at 5");
    check({112'd0, outStrb}, 128'h00E0, "R5 lanes 5..7");
    send(32'd9, 3'd4, PATTERN, "R5 full at 9");
    check({112'd0, outStrb}, 128'hFE00, "R5 lanes 9..15");
  endtask

  task automatic tOversize();
    for (int s = 5; s < 8; s++) begin
      send(32'd0, 3'(s), PATTERN, "R7 oversize");
      check({112'd0, outStrb}, 128'hFFFF, "R7 full mask");
      check(outData, PATTERN, "R7 full data");
    end
  endtask

  task automatic tHighAddr();
    logic [15:0]  refStrb;
    logic [127:0] refData;
    send(32'd6, 3'd1, PATTERN, "R8 base");
    refStrb = outStrb; refData = outData;
    send(32'hABCD_1236, 3'd1, PATTERN, "R8 high bits");
    check({112'd0, outStrb}, {112'd0, refStrb}, "R8 strb unchanged");
    check(outData, refData, "R8 data unchanged");
  endtask

  task automatic tSweep();
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 8; s++)
        send(32'(a), 3'(s), PATTERN ^ {16{8'(a*8+s)}}, "R1 R2 R6 sweep");
  endtask

  task automatic tLatency();
    @(negedge clk);
    inValid = 1'b1; inAddr = 32'd4; inSize = 3'd2; inData = PATTERN;
    #1;
    check({127'd0, outValid}, 128'd0, "R9 nothing before edge");
    @(negedge clk);
    inValid = 1'b0;
    check({112'd0, outStrb}, 128'h00F0, "R9 result after edge");
    @(negedge clk);
    check({127'd0, outValid}, 128'd0, "R11 drained valid");
    check({112'd0, outStrb}, 128'd0, "R11 drained strb");
  endtask

  task automatic tBackpressure();
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; inAddr = 32'd2; inSize = 3'd1; inData = PATTERN;
    @(negedge clk);
    inAddr = 32'd8; inSize = 3'd3; inData = ~PATTERN;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({127'd0, inReady}, 128'd0, "R10 ready low when stalled");
      check({112'd0, outStrb}, 128'h000C, "R10 strb held");
      check(outData, modelData(32'd2, 3'd1, PATTERN), "R10 data held");
    end
    outReady = 1'b1;
    #1;
    check({127'd0, inReady}, 128'd1, "R12 ready with drain");
    @(negedge clk);
    inValid = 1'b0;
    check({112'd0, outStrb}, 128'hFF00, "R12 next taken on drain");
    check(outData, modelData(32'd8, 3'd3, ~PATTERN), "R12 next data");
  endtask

  task automatic tStream();
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      inAddr = 32'(k * 4); inSize = 3'd2; inData = PATTERN;
      @(negedge clk);
      check({127'd0, outValid}, 128'd1, "R12 stream valid");
      check({112'd0, outStrb}, {112'd0, modelStrb(32'(k*4), 3'd2)}, "R12 stream strb");
    end
    inValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExamples();
    tUnaligned();
    tOversize();
    tHighAddr();
    tSweep();
    tLatency();
    tBackpressure();
    tStream();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule